// File: doc/BRIEF.md
# Bitwise Logic Unit with Combine

This unit is the logic-operation slice of a 64-bit execution datapath. A request carries two source operands (three for the multiplex operation), a 3-bit function code that picks one of eight two-input bitwise functions, a separate multiplex-select bit, a 2-bit combine mode and a 2-bit chunk-size code. The bitwise function is applied to the full register width.

When a combine mode is requested, a second step follows. Each byte of the intermediate result is reduced with AND or with OR, and the single reduced bit is then spread across all eight bits of that byte in the output. The multiplex operation ignores the function, combine and size fields. It takes each bit from operand B where the mask is 1 and from operand A where the mask is 0.

A request whose combine step names a chunk other than a byte, or uses the reserved combine code, is refused: the result is zero and an illegal flag is raised. The result and flag appear one clock after a valid request. A plain bitwise operation ignores the size field.

Top module: `logicCombineUnit`

## Requirements
- R1: Function codes act on the full 64-bit width: 0 = A&B, 1 = A|B, 2 = A^B, 5 = ~(A&B), 6 = ~(A|B), 7 = ~(A^B).
- R2: Function code 3 yields A & ~B and function code 4 yields A | ~B.
- R3: With combine code 1 (AND) and size code 0 (byte), each output byte is 8'hFF when all eight bits of that byte of the function result are 1, and 8'h00 otherwise.
- R4: With combine code 2 (OR) and size code 0 (byte), each output byte is 8'hFF when any bit of that byte of the function result is 1, and 8'h00 otherwise.
- R5: With combine code 0 (none), the size code has no effect on the result and never raises the illegal flag.
- R6: A request with the mux bit clear and with combine code 3, or with combine code 1 or 2 and a size code other than 0, produces outIllegal = 1 and outData = 0.
- R7: With inMux = 1 the result is (A & ~M) | (B & M) bit by bit, whatever the function, combine and size fields hold, and outIllegal is 0.
- R8: outValid in a cycle equals inValid of the previous clock edge, and the result of a request is present in that same cycle, including for back-to-back requests.
- R9: A synchronous active-high reset clears outValid, outData and outIllegal.
- R10: While inValid is low, outData and outIllegal keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| inFunc | input | 3 | Bitwise function code |
| inMux | input | 1 | Selects the masked multiplex operation |
| inCombine | input | 2 | 0 none, 1 AND per chunk, 2 OR per chunk, 3 reserved |
| inSize | input | 2 | Chunk-size code; 0 = byte |
| inA | input | 64 | First source operand |
| inB | input | 64 | Second source operand |
| inM | input | 64 | Multiplex mask operand |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outData | output | 64 | Result |
| outIllegal | output | 1 | Request was refused |

## Verification
The bench sweeps every combination of function, mux bit, combine and size code over operands that contain bytes which are all ones, all zeros and mixed after the function. A reduction that leaks bits between bytes or inverts AND and OR would leave output bytes that are neither 00 nor FF, or the wrong value. A size check applied to plain operations would wrongly refuse them, and a mux that honours the size or combine fields would raise the flag or return a reduced value. Idle cycles with changing inputs show whether the output register loads without a request, and a reset taken while a request is present shows whether reset wins.

// File: rtl/lcuPkg.sv
package lcuPkg;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_ANDN = 3'd3,
    FN_ORN  = 3'd4,
    FN_NAND = 3'd5,
    FN_NOR  = 3'd6,
    FN_XNOR = 3'd7
  } funcE;

  typedef enum logic [1:0] {
    CMB_NONE = 2'd0,
    CMB_AND  = 2'd1,
    CMB_OR   = 2'd2,
    CMB_RSV  = 2'd3
  } combineE;

  localparam logic [1:0] SIZE_BYTE = 2'd0;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;
    logic selMux;
    logic combEn;
    logic combOr;
    logic illegal;
  } lcuStrobeT;

endpackage

// File: rtl/lcuCtrl.sv
module lcuCtrl
  import lcuPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inMux,
  input  logic [1:0] inCombine,
  input  logic [1:0] inSize,
  output lcuStrobeT  strobe,
  output logic       outValid
);

  combineE cmb;
  logic    wantsComb;
  logic    sizeOk;

  always_comb begin
    cmb       = combineE'(inCombine);
    wantsComb = (cmb == CMB_AND) || (cmb == CMB_OR);
    sizeOk    = (inSize == SIZE_BYTE);

    strobe.load    = inValid;
    strobe.selMux  = inMux;
    strobe.combEn  = !inMux && wantsComb && sizeOk;
    strobe.combOr  = (cmb == CMB_OR);
    strobe.illegal = !inMux && ((cmb == CMB_RSV) || (wantsComb && !sizeOk));
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/lcuDatapath.sv
module lcuDatapath
  import lcuPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  lcuStrobeT        strobe,
  input  logic [2:0]       func,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opM,
  output logic [WIDTH-1:0] resData,
  output logic             resIllegal
);

  localparam int NCHUNK = WIDTH / CHUNK;

  logic [WIDTH-1:0] rawFn;
  logic [WIDTH-1:0] muxed;
  logic [WIDTH-1:0] combined;
  logic [WIDTH-1:0] nextData;

  // Stage 1: whole-register bitwise function
  always_comb begin
    unique case (funcE'(func))
      FN_AND:  rawFn = opA & opB;
      FN_OR:   rawFn = opA | opB;
      FN_XOR:  rawFn = opA ^ opB;
      FN_ANDN: rawFn = opA & ~opB;
      FN_ORN:  rawFn = opA | ~opB;
      FN_NAND: rawFn = ~(opA & opB);
      FN_NOR:  rawFn = ~(opA | opB);
      FN_XNOR: rawFn = ~(opA ^ opB);
      default: rawFn = '0;
    endcase
  end

  assign muxed = (opA & ~opM) | (opB & opM);

  // Stage 2: per-chunk reduction, spread back over the chunk
  for (genvar g = 0; g < NCHUNK; g++) begin : gChunk
    logic andRed;
    logic orRed;
    assign andRed = &rawFn[g*CHUNK +: CHUNK];
    assign orRed  = |rawFn[g*CHUNK +: CHUNK];
    assign combined[g*CHUNK +: CHUNK] = {CHUNK{strobe.combOr ? orRed : andRed}};
  end

  always_comb begin
    if (strobe.illegal)     nextData = '0;
    else if (strobe.selMux) nextData = muxed;
    else if (strobe.combEn) nextData = combined;
    else                    nextData = rawFn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resData    <= '0;
      resIllegal <= 1'b0;
    end else if (strobe.load) begin
      resData    <= nextData;
      resIllegal <= strobe.illegal;
    end
  end

endmodule

// File: rtl/logicCombineUnit.sv
module logicCombineUnit
  import lcuPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [2:0]       inFunc,
  input  logic             inMux,
  input  logic [1:0]       inCombine,
  input  logic [1:0]       inSize,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic [WIDTH-1:0] inM,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic             outIllegal
);

  lcuStrobeT strobe;

  lcuCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inMux     (inMux),
    .inCombine (inCombine),
    .inSize    (inSize),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  lcuDatapath #(
    .WIDTH (WIDTH),
    .CHUNK (CHUNK)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .func       (inFunc),
    .opA        (inA),
    .opB        (inB),
    .opM        (inM),
    .resData    (outData),
    .resIllegal (outIllegal)
  );

endmodule

// File: rtl/logicCombineUnitChecker.sv
module logicCombineUnitChecker #(
  parameter int WIDTH = 64,
  parameter int CHUNK = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inMux,
  input logic [1:0]       inCombine,
  input logic [1:0]       inSize,
  input logic [WIDTH-1:0] inA,
  input logic [WIDTH-1:0] inB,
  input logic [WIDTH-1:0] inM,
  input logic             outValid,
  input logic [WIDTH-1:0] outData,
  input logic             outIllegal
);

  function automatic logic chunksUniform(input logic [WIDTH-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WIDTH / CHUNK; i++) begin
      if (v[i*CHUNK +: CHUNK] != '0 && v[i*CHUNK +: CHUNK] != '1) ok = 1'b0;
    end
    return ok;
  endfunction

  // R8: valid follows the request by one edge
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R6: a refused request returns zero
  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIllegal) |-> (outData == '0));

  // R3 / R4: legal combine yields whole-byte values
  assert_combine_uniform_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inMux && (inCombine == 2'd1 || inCombine == 2'd2) && inSize == 2'd0)
      |=> (chunksUniform(outData) && !outIllegal));

  // R7: multiplex result and never refused
  assert_mux_result_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && inMux) |=> (!outIllegal &&
      outData == (($past(inA) & ~$past(inM)) | ($past(inB) & $past(inM)))));

  // R5: plain operations are never refused
  assert_plain_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inMux && inCombine == 2'd0) |=> !outIllegal);

  // R10: idle cycles leave the result alone
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outData) && $stable(outIllegal)));

  // R9: reset clears the outputs
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0 && !outIllegal));

endmodule

bind logicCombineUnit logicCombineUnitChecker #(
  .WIDTH (WIDTH),
  .CHUNK (CHUNK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inMux      (inMux),
  .inCombine  (inCombine),
  .inSize     (inSize),
  .inA        (inA),
  .inB        (inB),
  .inM        (inM),
  .outValid   (outValid),
  .outData    (outData),
  .outIllegal (outIllegal)
);

// File: tb/logicCombineUnit_tb.sv
`timescale 1ns/1ps
module logicCombineUnit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [2:0]  inFunc;
  logic        inMux;
  logic [1:0]  inCombine;
  logic [1:0]  inSize;
  logic [63:0] inA, inB, inM;
  logic        outValid;
  logic [63:0] outData;
  logic        outIllegal;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  logicCombineUnit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inFunc(inFunc), .inMux(inMux),
    .inCombine(inCombine), .inSize(inSize), .inA(inA), .inB(inB), .inM(inM),
    .outValid(outValid), .outData(outData), .outIllegal(outIllegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] refFunc(input int f, input logic [63:0] a, input logic [63:0] b);
    case (f)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return a & ~b;
      4: return a | ~b;
      5: return ~(a & b);
      6: return ~(a | b);
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic logic [63:0] refResult(input int f, input int mx, input int cmb, input int sz,
                                            input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] m, output logic ill);
    logic [63:0] r;
    ill = (mx == 0) && (cmb == 3 || (cmb != 0 && sz != 0));
    if (ill) return 64'd0;
    if (mx != 0) return (a & ~m) | (b & m);
    r = refFunc(f, a, b);
    if (cmb == 0) return r;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] byteV;
      byteV = r[i*8 +: 8];
      if (cmb == 1) r[i*8 +: 8] = (byteV == 8'hFF) ? 8'hFF : 8'h00;
      else          r[i*8 +: 8] = (byteV != 8'h00) ? 8'hFF : 8'h00;
    end
    return r;
  endfunction

  function automatic string pickTag(input int f, input int mx, input int cmb, input int sz);
    if (mx != 0) return "R7";
    if (cmb == 3 || (cmb != 0 && sz != 0)) return "R6";
    if (cmb == 1) return "R3";
    if (cmb == 2) return "R4";
    if (sz != 0) return "R5";
    if (f == 3 || f == 4) return "R2";
    return "R1";
  endfunction

  // Called at a negedge; returns at the following negedge after checking.
  task automatic doReq(input int f, input int mx, input int cmb, input int sz,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] m);
    logic [63:0] exp;
    logic expIll;
    string tag;
    inValid = 1'b1; inFunc = 3'(f); inMux = mx[0]; inCombine = 2'(cmb); inSize = 2'(sz);
    inA = a; inB = b; inM = m;
    exp = refResult(f, mx, cmb, sz, a, b, m, expIll);
    tag = pickTag(f, mx, cmb, sz);
    @(negedge clk);
    chk("R8", "outValid", 64'(outValid), 64'd1);
    chk(tag, "outData", outData, exp);
    chk(tag, "outIllegal", 64'(outIllegal), 64'(expIll));
    inValid = 1'b0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa [6];
    logic [63:0] pb [6];
    logic [63:0] seed;
    rst = 1'b1; inValid = 1'b0; inFunc = '0; inMux = 1'b0; inCombine = '0; inSize = '0;
    inA = '0; inB = '0; inM = '0;

    pa[0] = 64'hFFFF_FFFF_FFFF_FFFF; pb[0] = 64'h0000_0000_0000_0000;
    pa[1] = 64'hFFFF_FFFF_0000_0000; pb[1] = 64'hFFFF_0000_FFFF_0000;
    pa[2] = 64'hFF00_FF7F_0180_FFFE; pb[2] = 64'hFF00_00FF_FE7F_0001;
    pa[3] = 64'h00FF_0F0F_AA55_8001; pb[3] = 64'hFF00_F0F0_55AA_7FFE;
    seed = 64'h1234_5678_9ABC_DEF1;
    for (int p = 4; p < 6; p++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      pa[p] = seed;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      pb[p] = seed;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "outValid after reset", 64'(outValid), 64'd0);
    chk("R9", "outData after reset", outData, 64'd0);
    chk("R9", "outIllegal after reset", 64'(outIllegal), 64'd0);
    rst = 1'b0;

    // Sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int p = 0; p < 6; p++)
      for (int mx = 0; mx < 2; mx++)
        for (int cmb = 0; cmb < 4; cmb++)
          for (int sz = 0; sz < 4; sz++)
            for (int f = 0; f < 8; f++)
              doReq(f, mx, cmb, sz, pa[p], pb[p], pa[p] ^ {pb[p][31:0], pb[p][63:32]});

    // R10: idle cycles with changing inputs keep the result
    doReq(2, 0, 0, 0, pa[3], pb[3], 64'd0);
    for (int k = 0; k < 4; k++) begin
      logic [63:0] held;
      held = refFunc(2, pa[3], pb[3]);
      inFunc = 3'(k); inCombine = 2'(k); inSize = 2'(k); inMux = k[0];
      inA = pa[k]; inB = pb[k]; inM = pa[k+1];
      @(negedge clk);
      chk("R8", "outValid idle", 64'(outValid), 64'd0);
      chk("R10", "outData held", outData, held);
      chk("R10", "outIllegal held", 64'(outIllegal), 64'd0);
    end

    // R10: an illegal result is also held through idle
    doReq(0, 0, 1, 2, pa[0], pa[0], 64'd0);
    inA = pa[4]; inCombine = 2'd0;
    @(negedge clk);
    chk("R10", "illegal flag held", 64'(outIllegal), 64'd1);
    chk("R10", "zero data held", outData, 64'd0);

    // R9: reset wins over a present request
    doReq(1, 0, 0, 0, pa[0], pb[0], 64'd0);
    rst = 1'b1; inValid = 1'b1; inFunc = 3'd1; inA = pa[0]; inB = pb[0];
    @(negedge clk);
    chk("R9", "outValid under reset", 64'(outValid), 64'd0);
    chk("R9", "outData under reset", outData, 64'd0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule